// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This block looks up one capability in a device's configuration space. It reads that space through a byte-wide synchronous read port. After a single start pulse it checks whether the space carries a capability list at all. It then follows the short-form list held in the low 256 bytes. When asked, and when the space is the full 4 KB, it goes on to follow the long-form list that begins at offset 0x100. It stops at the first entry whose ID equals the requested one. It reports the offset of that entry and, for a long-form entry, the header's version field. While walking the short-form list it also notes whether the device presents the PCI Express capability.

The read port has a fixed latency of one cycle and no back-pressure. A read issued with `rd_en_o` high in one cycle returns its byte on `rd_data_i` in the next cycle. The memory must always answer in that cycle. Every read is made one at a time. Start, the search arguments and all results are plain level or pulse signals. Results stay stable from the `done_o` pulse until the next accepted start.

Top module: `cap_chain_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `found_o`, `error_o`, `is_pcie_o` and `rd_en_o` are 0, and `match_off_o` and `ext_ver_o` are 0.
- R2: The first read of a search is byte 6. If bit 4 of that byte is 0, the search ends with `found_o`=0 and `error_o`=0 and makes no further reads, whatever the mode.
- R3: The short-form walk reads its first pointer from byte 0x34. At each entry E, byte E is the ID and byte E+1 is the next pointer. Bits 1:0 of every pointer are taken as 0. A pointer below 0x40, including 0, ends the chain.
- R4: With `ext_sel_i`=0, the search stops at the first short-form entry whose ID equals `target_id_i[7:0]`, provided `target_id_i[15:8]` is 0. It then reports `found_o`=1 and `match_off_o`=E. A target with a nonzero upper byte never matches a short-form entry.
- R5: `is_pcie_o` is 1 when a short-form entry with ID 0x10 was visited during the search. In the extended mode the whole short-form chain is visited first.
- R6: The long-form walk runs only when `ext_sel_i`=1 and `space_4k_i`=1. It starts at 0x100 after the short-form chain ends. In the extended mode, short-form IDs are never reported as matches.
- R7: A long-form header is bytes H..H+3 taken little-endian. Bits 15:0 are the ID, bits 19:16 the version, and bits 31:20 the next offset. On an ID match the block reports `match_off_o`=H and `ext_ver_o` equal to the version. `ext_ver_o` is 0 when nothing is found.
- R8: A long-form next offset has bits 1:0 taken as 0. A next offset below 0x100, including 0, ends the walk with `found_o`=0.
- R9: If a 49th short-form entry or a 1025th long-form header would be visited, the search ends with `error_o`=1 and `found_o`=0.
- R10: `done_o` is a one-cycle pulse. `start_i` is ignored while `busy_o` is 1. Reads are issued only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| target_id_i | input | 16 | Capability ID to look for |
| ext_sel_i | input | 1 | 0: short-form list, 1: long-form list |
| space_4k_i | input | 1 | 1: space is 4 KB, 0: space is 256 B |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | 12 | Byte address of the read |
| rd_data_i | input | 8 | Read byte, valid the cycle after the request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | Target located |
| match_off_o | output | 12 | Offset of the matching entry |
| ext_ver_o | output | 4 | Version field of the matching long-form header |
| is_pcie_o | output | 1 | ID 0x10 seen in the short-form chain |
| error_o | output | 1 | Hop limit exceeded |

## Verification
The in-line properties check on every cycle that `done_o` never lasts two cycles and that reads happen only while busy. They also check that entry reads stay aligned and inside the right region for each list, that long-form reads occur only in the 4 KB extended mode, and that the hop counters never pass their limits. Whether the right entry was chosen needs the bench's configuration images. The same holds for the little-endian assembly of headers, whether `is_pcie_o` tracks the visited IDs, and whether pointer truncation and the end-of-chain rules work. The bench covers these with a standard image, a missing list, low pointers, self-looping chains, and a start pulse given mid-search.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_STAT_REQ,
    S_STAT_CHK,
    S_PTR_REQ,
    S_PTR_CHK,
    S_LID_REQ,
    S_LID_CHK,
    S_EXT_REQ,
    S_EXT_CAP,
    S_EXT_CHK
  } walk_state_t;
endpackage

// File: rtl/cw_hop_guard.sv
module cw_hop_guard #(
  parameter int LIMIT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr_i) cnt <= '0;
    else if (inc_i) cnt <= cnt + 1'b1;
  end

  assign full_o = (cnt == LIM);

  // R9
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LIM);
  // R9
  inc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n) inc_i |-> !full_o);
endmodule

// File: rtl/cw_hdr_asm.sv
module cw_hdr_asm #(
  parameter int NBYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       shift_i,
  input  logic [7:0]                 byte_i,
  output logic [$clog2(NBYTES)-1:0]  idx_o,
  output logic                       last_o,
  output logic [8*NBYTES-1:0]        word_o
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clr_i)   idx <= '0;
    else if (shift_i) idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] lane;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lane <= '0;
      else if (shift_i && idx == IW'(g))         lane <= byte_i;
    end
    assign word_o[8*g +: 8] = lane;
  end

  assign idx_o  = idx;
  assign last_o = (idx == LAST);

  // R7
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && last_o && !clr_i) |=> (idx_o == '0));
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
  import cw_pkg::*;
#(
  parameter int AW          = 12,
  parameter int LEG_HOP_MAX = 48,
  parameter int EXT_HOP_MAX = 1024,
  parameter int STATUS_OFF  = 6,
  parameter int CAPS_BIT    = 4,
  parameter int LEG_HEAD    = 'h34,
  parameter int LEG_FLOOR   = 'h40,
  parameter int EXT_BASE    = 'h100,
  parameter int PCIE_ID     = 'h10,
  parameter int HDR_BYTES   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [15:0]   target_id_i,
  input  logic          ext_sel_i,
  input  logic          space_4k_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o,
  output logic [AW-1:0] match_off_o,
  output logic [3:0]    ext_ver_o,
  output logic          is_pcie_o,
  output logic          error_o
);
  localparam int HW = 8 * HDR_BYTES;
  localparam int IW = $clog2(HDR_BYTES);
  localparam logic [AW-1:0] A_STATUS = AW'(STATUS_OFF);
  localparam logic [AW-1:0] A_HEAD   = AW'(LEG_HEAD);
  localparam logic [7:0]    P_FLOOR  = 8'(LEG_FLOOR);
  localparam logic [AW-1:0] A_EXT    = AW'(EXT_BASE);
  localparam logic [7:0]    ID_PCIE  = 8'(PCIE_ID);
  localparam logic [AW-1:0] A_ALIGN  = ~AW'(3);

  walk_state_t   st;
  logic [AW-1:0] ptr_addr, entry, ext_ptr, off_q;
  logic [15:0]   tgt_q;
  logic          ext_q, sp4k_q;
  logic          found_q, pcie_q, err_q, done_q;
  logic [3:0]    ver_q;

  logic          leg_full, ext_full;
  logic          leg_inc, ext_inc, guard_clr;
  logic          hdr_clr, hdr_shift, hdr_last;
  logic [IW-1:0] hdr_idx;
  logic [HW-1:0] hdr;

  logic [7:0]    leg_ptr;
  logic          leg_ok, leg_end, want_ext, leg_hit;
  logic [AW-1:0] ext_next;
  logic          ext_ok, ext_hit;

  assign leg_ptr  = rd_data_i & 8'hFC;
  assign leg_ok   = (leg_ptr >= P_FLOOR);
  assign leg_end  = (st == S_PTR_CHK) && !leg_ok;
  assign want_ext = ext_q && sp4k_q;
  assign leg_hit  = !ext_q && (tgt_q[15:8] == 8'h00) && (rd_data_i == tgt_q[7:0]);

  assign ext_next = hdr[HW-1:HW-AW] & A_ALIGN;
  assign ext_ok   = (ext_next >= A_EXT);
  assign ext_hit  = (hdr[15:0] == tgt_q);

  assign guard_clr = (st == S_IDLE) && start_i;
  assign leg_inc   = (st == S_PTR_CHK) && leg_ok && !leg_full;
  assign ext_inc   = (leg_end && want_ext) ||
                     ((st == S_EXT_CHK) && !ext_hit && ext_ok && !ext_full);
  assign hdr_shift = (st == S_EXT_CAP);
  assign hdr_clr   = (st == S_EXT_CHK) || (st == S_IDLE);

  cw_hop_guard #(.LIMIT(LEG_HOP_MAX)) u_leg_guard (
    .clk(clk), .rst_n(rst_n), .clr_i(guard_clr), .inc_i(leg_inc), .full_o(leg_full)
  );

  cw_hop_guard #(.LIMIT(EXT_HOP_MAX)) u_ext_guard (
    .clk(clk), .rst_n(rst_n), .clr_i(guard_clr), .inc_i(ext_inc), .full_o(ext_full)
  );

  cw_hdr_asm #(.NBYTES(HDR_BYTES)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr_i(hdr_clr), .shift_i(hdr_shift),
    .byte_i(rd_data_i), .idx_o(hdr_idx), .last_o(hdr_last), .word_o(hdr)
  );

  always_comb begin
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    unique case (st)
      S_STAT_REQ: begin rd_en_o = 1'b1; rd_addr_o = A_STATUS; end
      S_PTR_REQ:  begin rd_en_o = 1'b1; rd_addr_o = ptr_addr; end
      S_LID_REQ:  begin rd_en_o = 1'b1; rd_addr_o = entry; end
      S_EXT_REQ:  begin rd_en_o = 1'b1; rd_addr_o = ext_ptr + AW'(hdr_idx); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr_addr <= '0;
      entry    <= '0;
      ext_ptr  <= '0;
      off_q    <= '0;
      tgt_q    <= '0;
      ext_q    <= 1'b0;
      sp4k_q   <= 1'b0;
      found_q  <= 1'b0;
      pcie_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      ver_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          tgt_q   <= target_id_i;
          ext_q   <= ext_sel_i;
          sp4k_q  <= space_4k_i;
          found_q <= 1'b0;
          pcie_q  <= 1'b0;
          err_q   <= 1'b0;
          off_q   <= '0;
          ver_q   <= '0;
          st      <= S_STAT_REQ;
        end
        S_STAT_REQ: st <= S_STAT_CHK;
        S_STAT_CHK: begin
          if (rd_data_i[CAPS_BIT]) begin
            ptr_addr <= A_HEAD;
            st       <= S_PTR_REQ;
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_PTR_REQ: st <= S_PTR_CHK;
        S_PTR_CHK: begin
          if (!leg_ok) begin
            if (want_ext) begin
              ext_ptr <= A_EXT;
              st      <= S_EXT_REQ;
            end else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (leg_full) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            entry <= AW'(leg_ptr);
            st    <= S_LID_REQ;
          end
        end
        S_LID_REQ: st <= S_LID_CHK;
        S_LID_CHK: begin
          if (rd_data_i == ID_PCIE) pcie_q <= 1'b1;
          if (leg_hit) begin
            found_q <= 1'b1;
            off_q   <= entry;
            done_q  <= 1'b1;
            st      <= S_IDLE;
          end else begin
            ptr_addr <= entry + AW'(1);
            st       <= S_PTR_REQ;
          end
        end
        S_EXT_REQ: st <= S_EXT_CAP;
        S_EXT_CAP: st <= hdr_last ? S_EXT_CHK : S_EXT_REQ;
        S_EXT_CHK: begin
          if (ext_hit) begin
            found_q <= 1'b1;
            off_q   <= ext_ptr;
            ver_q   <= hdr[19:16];
            done_q  <= 1'b1;
            st      <= S_IDLE;
          end else if (!ext_ok) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (ext_full) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            ext_ptr <= ext_next;
            st      <= S_EXT_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_q;
  assign found_o     = found_q;
  assign match_off_o = off_q;
  assign ext_ver_o   = ver_q;
  assign is_pcie_o   = pcie_q;
  assign error_o     = err_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  // R10
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en_o |-> busy_o);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(start_i));
  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !(found_o && error_o));
  // R3
  leg_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LID_REQ) |-> (rd_addr_o >= AW'(LEG_FLOOR) && rd_addr_o < A_EXT && rd_addr_o[1:0] == 2'b00));
  // R8
  ext_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXT_REQ) |-> (rd_addr_o >= A_EXT));
  // R6
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXT_REQ) |-> (ext_q && sp4k_q));
  // R4
  found_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (match_off_o[1:0] == 2'b00));
endmodule

// File: tb/sim_cap_chain_walker.sv
module sim_cap_chain_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] target_id_i = '0;
  logic        ext_sel_i = 1'b0;
  logic        space_4k_i = 1'b1;
  logic        rd_en_o;
  logic [11:0] rd_addr_o;
  logic [7:0]  rd_data_i = '0;
  logic        busy_o, done_o, found_o, is_pcie_o, error_o;
  logic [11:0] match_off_o;
  logic [3:0]  ext_ver_o;

  logic [7:0] mem [0:4095];
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  cap_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_id_i(target_id_i),
    .ext_sel_i(ext_sel_i), .space_4k_i(space_4k_i), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .found_o(found_o), .match_off_o(match_off_o), .ext_ver_o(ext_ver_o),
    .is_pcie_o(is_pcie_o), .error_o(error_o)
  );

  // {ext_sel, space_4k, target, found, offset, version, is_pcie}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 16'h0005, 1'b1, 12'h050, 4'h0, 1'b0},  // R4 stop before 0x10
    {1'b0, 1'b1, 16'h0010, 1'b1, 12'h060, 4'h0, 1'b1},  // R4 R5
    {1'b0, 1'b0, 16'h0001, 1'b1, 12'h040, 4'h0, 1'b0},  // R3 first entry via 0x41
    {1'b0, 1'b1, 16'h0022, 1'b0, 12'h000, 4'h0, 1'b1},  // R3 chain end
    {1'b0, 1'b1, 16'h0105, 1'b0, 12'h000, 4'h0, 1'b1},  // R4 upper byte set
    {1'b1, 1'b1, 16'h0001, 1'b1, 12'h100, 4'h2, 1'b1},  // R7 first header
    {1'b1, 1'b1, 16'h0018, 1'b1, 12'h140, 4'h1, 1'b1},  // R7
    {1'b1, 1'b1, 16'h0015, 1'b1, 12'h200, 4'h3, 1'b1},  // R8 next 0x203 -> 0x200
    {1'b1, 1'b0, 16'h0015, 1'b0, 12'h000, 4'h0, 1'b1},  // R6 256 B space
    {1'b1, 1'b1, 16'h0005, 1'b0, 12'h000, 4'h0, 1'b1},  // R6 legacy id not reported
    {1'b1, 1'b1, 16'h9999, 1'b0, 12'h000, 4'h0, 1'b1}   // R8 end at zero
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  task automatic load_std();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[6]    = 8'h10;
    mem['h34] = 8'h41;
    mem['h40] = 8'h01; mem['h41] = 8'h50;
    mem['h50] = 8'h05; mem['h51] = 8'h63;
    mem['h60] = 8'h10; mem['h61] = 8'h00;
    put32('h100, 32'h1402_0001);
    put32('h140, 32'h2031_0018);
    put32('h200, 32'h0003_0015);
  endtask

  // Issue a start and wait for done; returns 1 on timely done.
  task automatic run(input logic es, input logic s4, input logic [15:0] t, output bit ok);
    @(negedge clk);
    ext_sel_i = es; space_4k_i = s4; target_id_i = t; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input string req, input bit ok, input logic f, input logic [11:0] off,
                              input logic [3:0] ver, input logic pc, input logic er);
    chk(req, "done seen", ok, 1);
    chk(req, "found", found_o, f);
    chk(req, "offset", match_off_o, off);
    chk(req, "version", ext_ver_o, ver);
    chk(req, "is_pcie", is_pcie_o, pc);
    chk(req, "error", error_o, er);
    @(negedge clk);
    chk("R10", "done one cycle", done_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++; tests++;
        $display("FAIL watchdog: got %0d cycles expected below 190000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    bit ok;
    load_std();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "found/err/pcie", {found_o, error_o, is_pcie_o}, 0);
    chk("R1", "rd_en", rd_en_o, 0);
    chk("R1", "offset/version", {match_off_o, ext_ver_o}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][35], VEC[v][34], VEC[v][33:18], ok);
      check_result($sformatf("vec%0d", v), ok, VEC[v][17], VEC[v][16:5], VEC[v][4:1], VEC[v][0], 1'b0);
    end

    // R2 status bit clear: no list, no further reads
    mem[6] = 8'hEF;
    run(1'b1, 1'b1, 16'h0001, ok);
    check_result("R2", ok, 0, 12'h000, 4'h0, 0, 0);
    mem[6] = 8'h10;

    // R3 first pointer below 0x40
    mem['h34] = 8'h3C;
    run(1'b0, 1'b1, 16'h0001, ok);
    check_result("R3", ok, 0, 12'h000, 4'h0, 0, 0);
    mem['h34] = 8'h41;

    // R8 extended next below 0x100 ends walk
    put32('h140, 32'h0FC1_0018);
    run(1'b1, 1'b1, 16'h0015, ok);
    check_result("R8", ok, 0, 12'h000, 4'h0, 1, 0);
    put32('h140, 32'h2031_0018);

    // R9 legacy self loop
    mem['h34] = 8'h40; mem['h41] = 8'h40;
    run(1'b0, 1'b1, 16'h0077, ok);
    check_result("R9", ok, 0, 12'h000, 4'h0, 0, 1);
    load_std();

    // R9 extended self loop
    put32('h100, 32'h1000_0001);
    run(1'b1, 1'b1, 16'h7777, ok);
    check_result("R9", ok, 0, 12'h000, 4'h0, 1, 1);
    load_std();

    // R10 start ignored while busy
    @(negedge clk);
    ext_sel_i = 1'b0; space_4k_i = 1'b1; target_id_i = 16'h0010; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "busy mid-run", busy_o, 1);
    ext_sel_i = 1'b1; target_id_i = 16'h0001; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    check_result("R10", ok, 1, 12'h060, 4'h0, 1, 0);
    chk("R10", "idle after", busy_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule